// File: doc/BRIEF.md
# Four-Window CHR-RAM Bank Translator

This block sits between the picture processor's address bus and a single CHR-RAM device on a cartridge whose RAM holds both the tile patterns and all four nametables. The 8 KiB pattern space is cut into four 2 KiB windows. Each window has its own 4-bit bank register, loaded by CPU writes to the top 8 KiB of CPU space. The block turns every picture-bus address into a RAM address, a chip enable and a nametable flag. All three outputs are combinational from the current address.

A static 2-bit mode input picks how the RAM is laid out. In linear mode the registers play no part and the picture address is passed straight through onto 16 KiB. In shared mode, 32 KiB are split into sixteen 2 KiB banks that any window may select. Nametables live in banks 0 and 15. In independent mode the two window-index address bits become the top RAM address bits, so each window reaches its own sixteen banks, 128 KiB in total. Nametables live in bank 15 of the first two windows.

Top module: `chr_window_mapper`

## Requirements
- R1: A CPU write (cpu_we high at a rising clock edge) with cpu_addr[15:13] = 3'b111 loads cpu_data[3:0] into bank register cpu_addr[1:0]. The new value is used from the next cycle on. cpu_data[7:4] and the other CPU address bits between them are ignored, and a write anywhere else changes no register.
- R2: While rst_n is low and after it rises, all four bank registers hold 0.
- R3: Mode 2'b00 (linear): ram_addr = {3'b000, ppu_addr[13:0]} for every address, whatever the registers hold.
- R4: Mode 2'b01 (shared), ppu_addr $0000-$1FFF: with window w = ppu_addr[12:11], ram_addr = {2'b00, bank[w], ppu_addr[10:0]}.
- R5: Mode 2'b10 or 2'b11 (independent), ppu_addr $0000-$1FFF: ram_addr = {ppu_addr[12:11], bank[w], ppu_addr[10:0]}.
- R6: In shared mode, addresses $2000-$27FF map to {2'b00, 4'h0, A10..A0} and addresses $2800-$2FFF map to {2'b00, 4'hF, A10..A0}.
- R7: In independent mode, addresses $2000-$2FFF map to {1'b0, ppu_addr[11], 4'hF, ppu_addr[10:0]}.
- R8: In shared and independent modes, $3000-$3EFF gives the same ram_addr as the address 4 KiB below it.
- R9: ram_ce = ppu_req, except that it is 0 for ppu_addr $3F00-$3FFF. It follows the inputs in the same cycle.
- R10: nt_flag is 1 for $2000-$2FFF in every mode and for $3000-$3EFF in shared and independent modes. It is 0 for $0000-$1FFF, for $3F00-$3FFF, and for $3000-$3EFF in linear mode. It does not depend on ppu_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bank registers |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Static layout: 00 linear, 01 shared, 10/11 independent |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address of the write |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 14 | Picture-bus address |
| ppu_req | input | 1 | Picture-bus access in progress |
| ram_addr | output | 17 | CHR-RAM address |
| ram_ce | output | 1 | CHR-RAM chip enable, active high |
| nt_flag | output | 1 | The current address is a nametable access |

## Verification
The bench loads distinct bank values into all four windows. A swapped window index or a wrong register decode therefore shows up as a bank number that belongs to a neighbour. It writes data with a non-zero upper nibble, and it writes to CPU addresses just outside the register range and within other regions. These writes catch a decoder that is too wide, or one that keeps the high data bits. The nametable tests probe the edges at $27FF/$2800 and the mirror area at $3000-$3EFF. A design that picks the nametable bank from the wrong address bit, or that lets A12 reach the RAM in the mirror area, would put nametables on top of pattern data. The palette boundary at $3EFF/$3F00, and the linear mode's bonus area reporting no nametable, catch an enable or flag decode that is off by one region.

// File: rtl/chr_map_pkg.sv
// Package: shared types and default sizes for the CHR-RAM window translator.
// Assumes a 14-bit picture address bus and four pattern windows of 2 KiB.
package chr_map_pkg;

    // Default sizes; the top module takes these as parameter defaults.
    localparam int unsigned DEF_BANK_W = 4;
    localparam int unsigned DEF_WIN_CNT = 4;
    localparam int unsigned DEF_OFS_W = 11;
    localparam int unsigned DEF_PPU_AW = 14;
    localparam int unsigned DEF_CPU_AW = 16;
    localparam int unsigned DEF_DATA_W = 8;

    // Layout selected by the static mode input.
    typedef enum logic [1:0] {
        MODE_LINEAR = 2'b00,
        MODE_SHARED = 2'b01,
        MODE_INDEP  = 2'b10,
        MODE_INDEP2 = 2'b11
    } chr_mode_e;

    // Class of picture-bus address.
    typedef enum logic [1:0] {
        RG_PATTERN = 2'd0,
        RG_NAMETBL = 2'd1,
        RG_BONUS   = 2'd2,
        RG_PALETTE = 2'd3
    } chr_region_e;

    // True when the mode gives each window its own set of banks.
    function automatic logic mode_is_indep(input chr_mode_e m);
        return (m == MODE_INDEP) || (m == MODE_INDEP2);
    endfunction

endpackage

// File: rtl/chr_bank_file.sv
// Module: chr_bank_file
// Holds one bank register per pattern window and returns the one addressed
// by the current window index. Assumes the caller has already decoded the
// write strobe; the register is chosen by the low bits of the CPU address.
module chr_bank_file #(
    parameter int unsigned BANK_W = 4,
    parameter int unsigned WIN_CNT = 4,
    localparam int unsigned WIN_W = $clog2(WIN_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIN_W-1:0]  wr_idx,
    input  logic [BANK_W-1:0] wr_bank,
    input  logic [WIN_W-1:0]  rd_idx,
    output logic [BANK_W-1:0] rd_bank
);

    logic [WIN_CNT-1:0][BANK_W-1:0] bank_q;

    // One register per window, cleared by reset, loaded when addressed.
    for (genvar g = 0; g < WIN_CNT; g++) begin : g_win
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else if (wr_en && (wr_idx == WIN_W'(g))) begin
                bank_q[g] <= wr_bank;
            end
        end
    end

    // Read port: pick the register for the window being accessed.
    always_comb begin
        rd_bank = bank_q[rd_idx];
    end

endmodule

// File: rtl/chr_region_decode.sv
// Module: chr_region_decode
// Classifies a picture-bus address as pattern, nametable, bonus RAM or
// palette. It also extracts the window index. Assumes the address width
// covers A13 and that the palette occupies the top 256 bytes.
module chr_region_decode
    import chr_map_pkg::*;
#(
    parameter int unsigned PPU_AW = 14,
    parameter int unsigned OFS_W = 11,
    parameter int unsigned WIN_CNT = 4,
    localparam int unsigned WIN_W = $clog2(WIN_CNT),
    localparam int unsigned TOP_BIT = PPU_AW - 1,
    localparam int unsigned HALF_BIT = PPU_AW - 2,
    localparam int unsigned PAL_W = PPU_AW - 8
) (
    input  logic [PPU_AW-1:0] ppu_addr,
    input  chr_mode_e         mode,
    output chr_region_e       region,
    output logic [WIN_W-1:0]  win_idx
);

    logic pal_hit;

    // Palette: every address bit above the low byte is set.
    always_comb begin
        pal_hit = &ppu_addr[PPU_AW-1 -: PAL_W];
    end

    // Region choice; the upper 4 KiB is bonus RAM only in linear mode.
    always_comb begin
        if (!ppu_addr[TOP_BIT]) begin
            region = RG_PATTERN;
        end else if (pal_hit) begin
            region = RG_PALETTE;
        end else if (ppu_addr[HALF_BIT] && (mode == MODE_LINEAR)) begin
            region = RG_BONUS;
        end else begin
            region = RG_NAMETBL;
        end
    end

    // Window index: the bits just above the in-bank offset.
    always_comb begin
        win_idx = ppu_addr[OFS_W +: WIN_W];
    end

endmodule

// File: rtl/chr_addr_xlate.sv
// Module: chr_addr_xlate
// Builds the CHR-RAM address from the region, the mode and the selected
// bank. It assumes the caller already picked the bank for the current window.
// Nametables use the lowest or highest bank; the mirror area
// above them drops A12.
module chr_addr_xlate
    import chr_map_pkg::*;
#(
    parameter int unsigned PPU_AW = 14,
    parameter int unsigned OFS_W = 11,
    parameter int unsigned BANK_W = 4,
    parameter int unsigned WIN_CNT = 4,
    localparam int unsigned WIN_W = $clog2(WIN_CNT),
    localparam int unsigned RAM_AW = WIN_W + BANK_W + OFS_W
) (
    input  logic [PPU_AW-1:0] ppu_addr,
    input  chr_mode_e         mode,
    input  chr_region_e       region,
    input  logic [WIN_W-1:0]  win_idx,
    input  logic [BANK_W-1:0] sel_bank,
    output logic [RAM_AW-1:0] ram_addr
);

    logic [OFS_W-1:0]  ofs;
    logic              nt_half;
    logic [BANK_W-1:0] nt_bank_sh;
    logic [WIN_W-1:0]  nt_win_ind;

    // Offset within a bank and the nametable half select (A11).
    always_comb begin
        ofs = ppu_addr[OFS_W-1:0];
        nt_half = ppu_addr[OFS_W];
    end

    // Nametable bank in shared mode: lowest bank or highest bank.
    always_comb begin
        nt_bank_sh = nt_half ? {BANK_W{1'b1}} : {BANK_W{1'b0}};
    end

    // Nametable window in independent mode: first or second window.
    always_comb begin
        nt_win_ind = WIN_W'(nt_half);
    end

    // Final address multiplexer by mode and region.
    always_comb begin
        if (mode == MODE_LINEAR) begin
            ram_addr = RAM_AW'(ppu_addr);
        end else if (mode_is_indep(mode)) begin
            if (region == RG_PATTERN) begin
                ram_addr = {win_idx, sel_bank, ofs};
            end else begin
                ram_addr = {nt_win_ind, {BANK_W{1'b1}}, ofs};
            end
        end else begin
            if (region == RG_PATTERN) begin
                ram_addr = {{WIN_W{1'b0}}, sel_bank, ofs};
            end else begin
                ram_addr = {{WIN_W{1'b0}}, nt_bank_sh, ofs};
            end
        end
    end

endmodule

// File: rtl/chr_window_mapper.sv
// Module: chr_window_mapper (top)
// Translates picture-bus addresses into CHR-RAM addresses for a cartridge
// whose RAM holds the four windowed pattern banks and four-screen
// nametables. CPU writes with A15..A13 = 111 load the window bank registers.
// Assumes mode is static during operation and the reset is synchronous.
module chr_window_mapper
    import chr_map_pkg::*;
#(
    parameter int unsigned BANK_W = DEF_BANK_W,
    parameter int unsigned WIN_CNT = DEF_WIN_CNT,
    parameter int unsigned OFS_W = DEF_OFS_W,
    parameter int unsigned PPU_AW = DEF_PPU_AW,
    parameter int unsigned CPU_AW = DEF_CPU_AW,
    parameter int unsigned DATA_W = DEF_DATA_W,
    localparam int unsigned WIN_W = $clog2(WIN_CNT),
    localparam int unsigned RAM_AW = WIN_W + BANK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              ppu_req,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_ce,
    output logic              nt_flag
);

    chr_mode_e         mode_e;
    chr_region_e       region;
    logic [WIN_W-1:0]  win_idx;
    logic [BANK_W-1:0] sel_bank;
    logic              reg_wr;

    // Cast the static mode pins to the package type.
    always_comb begin
        mode_e = chr_mode_e'(mode);
    end

    // Register write decode: top three CPU address bits all set.
    always_comb begin
        reg_wr = cpu_we && (&cpu_addr[CPU_AW-1 -: 3]);
    end

    chr_bank_file #(
        .BANK_W (BANK_W),
        .WIN_CNT(WIN_CNT)
    ) u_banks (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .wr_idx (cpu_addr[WIN_W-1:0]),
        .wr_bank(cpu_data[BANK_W-1:0]),
        .rd_idx (win_idx),
        .rd_bank(sel_bank)
    );

    chr_region_decode #(
        .PPU_AW (PPU_AW),
        .OFS_W  (OFS_W),
        .WIN_CNT(WIN_CNT)
    ) u_region (
        .ppu_addr(ppu_addr),
        .mode    (mode_e),
        .region  (region),
        .win_idx (win_idx)
    );

    chr_addr_xlate #(
        .PPU_AW (PPU_AW),
        .OFS_W  (OFS_W),
        .BANK_W (BANK_W),
        .WIN_CNT(WIN_CNT)
    ) u_xlate (
        .ppu_addr(ppu_addr),
        .mode    (mode_e),
        .region  (region),
        .win_idx (win_idx),
        .sel_bank(sel_bank),
        .ram_addr(ram_addr)
    );

    // Output strobes: enable off in the palette, flag on for nametables.
    always_comb begin
        ram_ce = ppu_req && (region != RG_PALETTE);
        nt_flag = (region == RG_NAMETBL);
    end

endmodule

// File: rtl/chr_window_mapper_chk.sv
// Module: chr_window_mapper_chk
// Property checker attached to the top module by bind. It looks only at the
// top-level ports.
module chr_window_mapper_chk #(
    parameter int unsigned BANK_W = 4,
    parameter int unsigned OFS_W = 11,
    parameter int unsigned PPU_AW = 14,
    parameter int unsigned CPU_AW = 16,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned RAM_AW = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              cpu_we,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_data,
    input logic [PPU_AW-1:0] ppu_addr,
    input logic              ppu_req,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              ram_ce,
    input logic              nt_flag
);

    AST_PALETTE_NO_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (ppu_addr[13:8] == 6'h3F) |-> !ram_ce);  // R9

    AST_LINEAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (ram_addr == {3'b000, ppu_addr}));  // R3

    AST_INDEP_WINDOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !ppu_addr[13]) |-> (ram_addr[16:15] == ppu_addr[12:11]));  // R5

    AST_SHARED_NT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b01) && ppu_addr[13] && (ppu_addr[13:8] != 6'h3F))
        |-> (ram_addr[14:11] == {4{ppu_addr[11]}}));  // R6

    AST_INDEP_NT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && ppu_addr[13] && (ppu_addr[13:8] != 6'h3F))
        |-> (ram_addr == {1'b0, ppu_addr[11], 4'hF, ppu_addr[10:0]}));  // R7

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cpu_we && (cpu_addr[15:13] == 3'b111))
        |=> (!((mode == 2'b01) && !ppu_addr[13] && (ppu_addr[12:11] == $past(cpu_addr[1:0])))
             || (ram_addr[14:11] == $past(cpu_data[3:0]))));  // R1

    AST_PATTERN_NO_NT: assert property (@(posedge clk) disable iff (!rst_n)
        !ppu_addr[13] |-> !nt_flag);  // R10

endmodule

bind chr_window_mapper chr_window_mapper_chk #(
    .BANK_W(BANK_W),
    .OFS_W (OFS_W),
    .PPU_AW(PPU_AW),
    .CPU_AW(CPU_AW),
    .DATA_W(DATA_W),
    .RAM_AW(RAM_AW)
) u_chk (.*);

// File: tb/sim_chr_window_mapper.sv
// Directed bench for chr_window_mapper: one task per scenario.
module sim_chr_window_mapper;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b01;
    logic        cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic [13:0] ppu_addr = '0;
    logic        ppu_req = 1'b0;
    logic [16:0] ram_addr;
    logic        ram_ce;
    logic        nt_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [3:0] bk [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    chr_window_mapper u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_data(cpu_data), .ppu_addr(ppu_addr),
        .ppu_req(ppu_req), .ram_addr(ram_addr), .ram_ce(ram_ce),
        .nt_flag(nt_flag)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // One CPU write, driven at the falling edge and taken at the next rising edge.
    task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    // Present a picture address and let the combinational outputs settle.
    task automatic look(input logic [13:0] a);
        ppu_addr = a;
        #1;
    endtask

    task automatic t_reset();
        mode = 2'b01;
        for (int w = 0; w < 4; w++) begin
            look(14'((w << 11) | 11'h155));
            chk("R2 reset bank", {15'd0, ram_addr}, 32'(17'(11'h155)));
        end
    endtask

    task automatic t_shared_load();
        logic [7:0] vals [4] = '{8'hA3, 8'h55, 8'hF9, 8'h0C};
        mode = 2'b01;
        for (int w = 0; w < 4; w++) begin
            cpu_wr(16'hE000 | 16'(w), vals[w]);
            bk[w] = vals[w][3:0];
        end
        for (int w = 0; w < 4; w++) begin
            look(14'((w << 11) | 11'h7FF));
            chk("R1/R4 shared window", {15'd0, ram_addr}, 32'({2'b00, bk[w], 11'h7FF}));
        end
        cpu_wr(16'hFFFE, 8'h06);
        bk[2] = 4'h6;
        look(14'h1000);
        chk("R1 mirror register addr", {15'd0, ram_addr}, 32'({2'b00, 4'h6, 11'h000}));
    endtask

    task automatic t_nonreg_write();
        mode = 2'b01;
        cpu_wr(16'hDFFD, 8'h07);
        cpu_wr(16'hC001, 8'h0E);
        cpu_wr(16'h6001, 8'h0B);
        look(14'h0801);
        chk("R1 non-register write ignored", {15'd0, ram_addr}, 32'({2'b00, bk[1], 11'h001}));
    endtask

    task automatic t_indep();
        for (int m = 2; m < 4; m++) begin
            mode = 2'(m);
            for (int w = 0; w < 4; w++) begin
                look(14'((w << 11) | 11'h2A5));
                chk("R5 independent window", {15'd0, ram_addr}, 32'({2'(w), bk[w], 11'h2A5}));
            end
        end
    endtask

    task automatic t_linear();
        mode = 2'b00;
        look(14'h0ABC);
        chk("R3 linear pattern", {15'd0, ram_addr}, 32'h0ABC);
        look(14'h1FFF);
        chk("R3 linear pattern top", {15'd0, ram_addr}, 32'h1FFF);
        look(14'h2400);
        chk("R3 linear nametable", {15'd0, ram_addr}, 32'h2400);
        chk("R10 linear nametable flag", {31'd0, nt_flag}, 32'd1);
        look(14'h3123);
        chk("R3 linear bonus", {15'd0, ram_addr}, 32'h3123);
        chk("R10 linear bonus no flag", {31'd0, nt_flag}, 32'd0);
    endtask

    task automatic t_nt_shared();
        mode = 2'b01;
        look(14'h2000);
        chk("R6 shared nt low", {15'd0, ram_addr}, 32'({2'b00, 4'h0, 11'h000}));
        chk("R10 shared nt flag", {31'd0, nt_flag}, 32'd1);
        look(14'h27FF);
        chk("R6 shared nt edge", {15'd0, ram_addr}, 32'({2'b00, 4'h0, 11'h7FF}));
        look(14'h2800);
        chk("R6 shared nt high", {15'd0, ram_addr}, 32'({2'b00, 4'hF, 11'h000}));
        look(14'h3C56);
        chk("R8 shared mirror", {15'd0, ram_addr}, 32'({2'b00, 4'hF, 11'h456}));
        chk("R10 shared mirror flag", {31'd0, nt_flag}, 32'd1);
        look(14'h0123);
        chk("R10 pattern no flag", {31'd0, nt_flag}, 32'd0);
    endtask

    task automatic t_nt_indep();
        mode = 2'b10;
        look(14'h2345);
        chk("R7 indep nt first", {15'd0, ram_addr}, 32'({2'b00, 4'hF, 11'h345}));
        look(14'h2B45);
        chk("R7 indep nt second", {15'd0, ram_addr}, 32'({2'b01, 4'hF, 11'h345}));
        look(14'h3B45);
        chk("R8 indep mirror", {15'd0, ram_addr}, 32'({2'b01, 4'hF, 11'h345}));
        look(14'h3EFF);
        chk("R8 indep mirror top", {15'd0, ram_addr}, 32'({2'b01, 4'hF, 11'h6FF}));
    endtask

    task automatic t_enable();
        mode = 2'b01;
        ppu_req = 1'b1;
        look(14'h3EFF);
        chk("R9 ce below palette", {31'd0, ram_ce}, 32'd1);
        look(14'h3F00);
        chk("R9 ce palette", {31'd0, ram_ce}, 32'd0);
        chk("R10 palette no flag", {31'd0, nt_flag}, 32'd0);
        look(14'h0400);
        chk("R9 ce pattern", {31'd0, ram_ce}, 32'd1);
        ppu_req = 1'b0;
        look(14'h0400);
        chk("R9 ce idle", {31'd0, ram_ce}, 32'd0);
        look(14'h2000);
        chk("R10 flag without request", {31'd0, nt_flag}, 32'd1);
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst_n = 1'b0;
        cpu_addr = 16'hE002; cpu_data = 8'h09; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int w = 0; w < 4; w++) bk[w] = 4'h0;
        mode = 2'b01;
        look(14'h1000);
        chk("R2 reset clears and blocks writes", {15'd0, ram_addr}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_shared_load();
        t_nonreg_write();
        t_indep();
        t_linear();
        t_nt_shared();
        t_nt_indep();
        t_enable();
        t_reset_again();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule